// File: doc/BRIEF.md
# 32-bit Privilege Segment Decoder

This block sorts a 32-bit virtual address into one of five fixed regions of the address space and decides what the load/store path must do next. It considers the region, the current privilege level and an error-level flag. There are three possible results. The address may be sent on to the translation buffer. It may be turned directly into a physical address with read and write allowed. Or it may be rejected as an address error.

The lower half of the space is the user region. It is reachable from every privilege level and is normally translated. When the error-level flag is raised, the user region maps one-to-one instead, with no lookup. The upper half holds four regions of 512 MB each. The first two are unmapped windows onto the low 512 MB of physical memory, and only kernel code may use them. The third is translated and open to supervisor and kernel. The fourth is translated and open to kernel only.

The decoder is purely combinational and holds no state. It sits between address generation and the translation lookup.

Top module: `seg_decoder`

## Requirements
- R1: With errLevel low, an address in 0x00000000..0x7FFFFFFF gives mapReq=1, badAddr=0, canRead=canWrite=0 and physAddr=0, whatever privMode is.
- R2: With errLevel high, an address in 0x00000000..0x7FFFFFFF gives mapReq=0, badAddr=0, canRead=canWrite=1 and physAddr equal to vAddr, whatever privMode is.
- R3: In kernel mode, an address in 0x80000000..0x9FFFFFFF gives mapReq=0, badAddr=0, canRead=canWrite=1 and physAddr = vAddr - 0x80000000.
- R4: In kernel mode, an address in 0xA0000000..0xBFFFFFFF gives mapReq=0, badAddr=0, canRead=canWrite=1 and physAddr = vAddr - 0xA0000000.
- R5: An address in 0xC0000000..0xDFFFFFFF gives mapReq=1 in supervisor or kernel mode, and is an address error in user mode.
- R6: An address in 0xE0000000..0xFFFFFFFF gives mapReq=1 in kernel mode only, and is an address error in any other mode.
- R7: privMode is encoded as 2'b00 kernel, 2'b01 supervisor, 2'b10 user, and 2'b11 is treated as user. Every access that the privilege level does not permit gives badAddr=1, mapReq=0, canRead=canWrite=0 and physAddr=0.
- R8: Exactly one of mapReq, badAddr and canRead is high for every input. canWrite always equals canRead. errLevel has no effect on any output when vAddr is 0x80000000 or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vAddr | input | 32 | Virtual address to classify |
| privMode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 10/11 user |
| errLevel | input | 1 | Error-level flag; makes the user region identity mapped |
| mapReq | output | 1 | Address must be looked up in the translation buffer |
| physAddr | output | 32 | Direct physical address, zero unless canRead is high |
| canRead | output | 1 | Direct access allowed for reading |
| canWrite | output | 1 | Direct access allowed for writing |
| badAddr | output | 1 | Address error for this privilege level |

## Verification
The block has no stored state. A wrong decode therefore shows at the ports in the same cycle the inputs change, as a wrong outcome flag or a wrong physical address. If the control side picks the wrong region or privilege rule, the outcome flags change together: a translated access becomes an error, or an error becomes a direct access. If the datapath picks the wrong offset, the upper three bits of physAddr do not match, or a value leaks through when it should be zero. The bench sweeps every region, every mode code and both error-level values, using addresses at each region's edges and inside it, so a single wrong term shows up on the first input pattern that reaches it.

// File: rtl/seg_decoder_pkg.sv
package seg_decoder_pkg;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'b00,
    PRIV_SUPER  = 2'b01,
    PRIV_USER   = 2'b10,
    PRIV_USER_ALT = 2'b11
  } privLevel_t;

  typedef enum logic [2:0] {
    REGION_USER,
    REGION_WIN_LO,
    REGION_WIN_HI,
    REGION_SUPER,
    REGION_KERNEL
  } region_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic passIdent;
    logic passWindow;
    logic needLookup;
    logic fault;
  } segStrobe_t;

endpackage

// File: rtl/seg_region_classify.sv
module seg_region_classify #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]              vAddr,
  output seg_decoder_pkg::region_t       region
);
  import seg_decoder_pkg::*;

  localparam int TOP_BITS = 3;
  localparam int TOP_LSB  = ADDR_W - TOP_BITS;

  logic [TOP_BITS-1:0] topBits;
  assign topBits = vAddr[ADDR_W-1:TOP_LSB];

  always_comb begin
    unique casez (topBits)
      3'b0??:  region = REGION_USER;
      3'b100:  region = REGION_WIN_LO;
      3'b101:  region = REGION_WIN_HI;
      3'b110:  region = REGION_SUPER;
      default: region = REGION_KERNEL;
    endcase
  end

endmodule

// File: rtl/seg_control.sv
module seg_control (
  input  seg_decoder_pkg::region_t   region,
  input  logic [1:0]                 privMode,
  input  logic                       errLevel,
  output seg_decoder_pkg::segStrobe_t strobe
);
  import seg_decoder_pkg::*;

  logic isKernel;
  logic isSuper;

  always_comb begin
    isKernel = (privMode == PRIV_KERNEL);
    isSuper  = (privMode == PRIV_SUPER);
  end

  always_comb begin
    strobe = '0;
    unique case (region)
      REGION_USER: begin
        if (errLevel) strobe.passIdent  = 1'b1;
        else          strobe.needLookup = 1'b1;
      end
      REGION_WIN_LO, REGION_WIN_HI: begin
        if (isKernel) strobe.passWindow = 1'b1;
        else          strobe.fault      = 1'b1;
      end
      REGION_SUPER: begin
        if (isKernel || isSuper) strobe.needLookup = 1'b1;
        else                     strobe.fault      = 1'b1;
      end
      default: begin
        if (isKernel) strobe.needLookup = 1'b1;
        else          strobe.fault      = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]           vAddr,
  input  seg_decoder_pkg::segStrobe_t strobe,
  output logic [ADDR_W-1:0]           physAddr,
  output logic                        canRead,
  output logic                        canWrite,
  output logic                        mapReq,
  output logic                        badAddr
);
  localparam int WIN_BITS = ADDR_W - 3;

  logic [ADDR_W-1:0] windowAddr;
  // both windows alias the bottom of physical memory; dropping the
  // region bits equals subtracting the region base
  assign windowAddr = {{(ADDR_W-WIN_BITS){1'b0}}, vAddr[WIN_BITS-1:0]};

  always_comb begin
    physAddr = '0;
    if (strobe.passIdent)       physAddr = vAddr;
    else if (strobe.passWindow) physAddr = windowAddr;
  end

  assign canRead  = strobe.passIdent | strobe.passWindow;
  assign canWrite = strobe.passIdent | strobe.passWindow;
  assign mapReq   = strobe.needLookup;
  assign badAddr  = strobe.fault;

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vAddr,
  input  logic [1:0]        privMode,
  input  logic              errLevel,
  output logic              mapReq,
  output logic [ADDR_W-1:0] physAddr,
  output logic              canRead,
  output logic              canWrite,
  output logic              badAddr
);
  import seg_decoder_pkg::*;

  region_t    region;
  segStrobe_t strobe;

  seg_region_classify #(.ADDR_W(ADDR_W)) classify (
    .vAddr (vAddr),
    .region(region)
  );

  seg_control control (
    .region  (region),
    .privMode(privMode),
    .errLevel(errLevel),
    .strobe  (strobe)
  );

  seg_datapath #(.ADDR_W(ADDR_W)) datapath (
    .vAddr   (vAddr),
    .strobe  (strobe),
    .physAddr(physAddr),
    .canRead (canRead),
    .canWrite(canWrite),
    .mapReq  (mapReq),
    .badAddr (badAddr)
  );

  logic inKnown;
  assign inKnown = !$isunknown({vAddr, privMode, errLevel});

  always_comb begin
    if (inKnown) begin
      AST_ONE_OUTCOME: assert ($countones({mapReq, badAddr, canRead}) == 1); // R8
      AST_RW_PAIR: assert (canRead == canWrite); // R8
      AST_USER_CONFINED: assert (!(privMode[1] && vAddr[ADDR_W-1]) || badAddr); // R7
      AST_FAULT_ZERO: assert (!badAddr || physAddr == '0); // R7
      AST_WINDOW_LOW: assert (!(canRead && vAddr[ADDR_W-1]) || physAddr[ADDR_W-1:ADDR_W-3] == 3'b000); // R3
      AST_ERL_IDENT: assert (!(errLevel && !vAddr[ADDR_W-1]) || (physAddr == vAddr && canRead)); // R2
      AST_KERNEL_NOFAULT: assert (privMode != 2'b00 || !badAddr); // R6
    end
  end

endmodule

// File: tb/seg_decoder_test.sv
`timescale 1ns/1ps
module seg_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vAddr = '0;
  logic [1:0]  privMode = '0;
  logic        errLevel = 1'b0;
  logic        mapReq, canRead, canWrite, badAddr;
  logic [31:0] physAddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_decoder uut (
    .vAddr(vAddr), .privMode(privMode), .errLevel(errLevel),
    .mapReq(mapReq), .physAddr(physAddr), .canRead(canRead),
    .canWrite(canWrite), .badAddr(badAddr)
  );

  task automatic checkOut(input string req, input logic eMap, input logic eRw,
                          input logic eBad, input logic [31:0] ePhys);
    checks++;
    if (mapReq !== eMap || canRead !== eRw || canWrite !== eRw ||
        badAddr !== eBad || physAddr !== ePhys) begin
      failures++;
      $display("FAIL %s addr=%h mode=%b erl=%b actual map=%b rd=%b wr=%b bad=%b phys=%h expected map=%b rw=%b bad=%b phys=%h",
               req, vAddr, privMode, errLevel, mapReq, canRead, canWrite, badAddr,
               physAddr, eMap, eRw, eBad, ePhys);
    end
  endtask

  task automatic applyAndCheck(input logic [31:0] a, input logic [1:0] m, input logic e);
    logic kern, sup, eMap, eRw, eBad;
    logic [31:0] ePhys;
    string req;
    @(posedge clk);
    vAddr = a; privMode = m; errLevel = e;
    kern = (m == 2'b00);
    sup  = (m == 2'b01);
    eMap = 0; eRw = 0; eBad = 0; ePhys = '0;
    if (a <= 32'h7FFF_FFFF) begin
      if (e) begin eRw = 1; ePhys = a; req = "R2"; end
      else   begin eMap = 1; req = "R1"; end
    end else if (a < 32'hA000_0000) begin
      if (kern) begin eRw = 1; ePhys = a - 32'h8000_0000; req = "R3"; end
      else      begin eBad = 1; req = "R7"; end
    end else if (a < 32'hC000_0000) begin
      if (kern) begin eRw = 1; ePhys = a - 32'hA000_0000; req = "R4"; end
      else      begin eBad = 1; req = "R7"; end
    end else if (a < 32'hE000_0000) begin
      if (kern || sup) eMap = 1; else eBad = 1;
      req = "R5";
    end else begin
      if (kern) eMap = 1; else eBad = 1;
      req = "R6";
    end
    if (a[31] && e) req = {req, "/R8"};
    @(negedge clk);
    checkOut(req, eMap, eRw, eBad, ePhys);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle inputs: kernel, address zero, translated user region (R1)
    checkOut("R1 idle", 1'b1, 1'b0, 1'b0, 32'h0);
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] low;
        case (k)
          0: low = 32'h0000_0000;
          1: low = 32'h1FFF_FFFF;
          2: low = 32'h0ACE_1234;
          3: low = 32'h1555_5555;
          4: low = 32'h0AAA_AAAA;
          default: low = (r * 32'h0123_4567 + 32'h00F0_F0F1) & 32'h1FFF_FFFF;
        endcase
        for (int m = 0; m < 4; m++) begin
          for (int e = 0; e < 2; e++) begin
            applyAndCheck({r[2:0], low[28:0]}, m[1:0], e[0]);
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule